// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte-wide stream and places them in memory buffers. Each buffer is described by a two-word descriptor in a ring: an info word and a buffer pointer. The CPU hands a descriptor to the block by setting its ownership bit and writing the buffer capacity into the length field. The block fills the buffer, then writes the info word back. The written-back word holds the byte count, the frame-start and frame-end flags, and the ownership bit cleared, which returns the descriptor to the CPU.

A frame longer than one buffer is spread over consecutive descriptors. The block sets a receive status bit when a frame has been fully written back. Before it touches memory, it applies a destination-address filter. The filter accepts a frame whose address equals the station address or the broadcast address; promiscuous mode accepts any address. When no descriptor is available for a frame, the block counts the frame as missed. A status bit is raised each time that counter wraps.

The block has one memory port. Reads return data on the cycle after `mem_rd`, and writes carry byte strobes. Configuration arrives on plain input ports, laid out like the control and station address words that software would program.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `s_ready` is 1, `stat_o` is 0, `miss_count` is 0, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: A frame is stored when its first six bytes equal the station address, where byte 0 is `cfg_addr_lo[7:0]` through byte 3 `cfg_addr_lo[31:24]`, byte 4 is `cfg_addr_hi[7:0]` and byte 5 is `cfg_addr_hi[15:8]`. Any other unicast address is dropped without a memory write.
- R3: A destination of six 0xFF bytes is accepted unless `cfg_ctrl[8]` is 1. With `cfg_ctrl[11]` set, every destination is accepted.
- R4: Descriptor i sits at `cfg_ring_base + 8*i`: the info word first, then the buffer pointer at +4. Only a descriptor whose info bit 31 is 1 is filled. Its capacity is info bits 10:0, and frame byte n of that buffer goes to pointer + n through a single-lane byte write.
- R5: On write-back the info word has bit 31 at 0 and bits 10:0 holding the number of bytes placed in the buffer. Bit 16 marks the buffer that holds the frame's first byte and bit 17 the one that holds its final byte. All other bits are 0, so a frame held in one buffer reads 0x0003_0000 plus its length.
- R6: A frame longer than the capacity continues into the next descriptors. Only the first buffer carries bit 16 and only the final one carries bit 17. A frame exactly as long as the capacity uses a single descriptor.
- R7: The descriptor index advances after every write-back and returns to 0 when it reaches `cfg_ctrl[31:24]`.
- R8: If the descriptor for a new accepted frame has bit 31 at 0, the whole frame is dropped, `miss_count` increments, and that descriptor is used for the next frame.
- R9: If a descriptor needed in the middle of a frame has bit 31 at 0, the rest of the frame is dropped and `miss_count` increments. The buffers already returned keep bit 16 without bit 17, and the index stays on the CPU-owned descriptor.
- R10: `stat_o[1]` is set when a frame's final write-back completes. `stat_o[4]` is set when `miss_count` wraps to 0. Each is cleared by a 1 on the same bit of `stat_w1c`.
- R11: Frames shorter than six bytes, and frames that begin while `cfg_ctrl[4]` is 0, are consumed and dropped. They cause no memory write and do not change `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 32 | Ring length [31:24], promiscuous [11], broadcast reject [8], receive enable [4] |
| cfg_ring_base | input | AW | Byte address of descriptor 0 |
| cfg_addr_lo | input | 32 | Station address bytes 0..3, byte 0 in bits 7:0 |
| cfg_addr_hi | input | 16 | Station address bytes 4..5, byte 4 in bits 7:0 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Block accepts the stream byte this cycle |
| mem_rd | output | 1 | Read word at mem_addr; data due next cycle |
| mem_wr | output | 1 | Write to memory with mem_wstrb |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data (byte replicated on all lanes for buffer writes) |
| mem_wstrb | output | 4 | Byte lane strobes |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| stat_o | output | 32 | Status: receive done [1], missed-counter wrap [4] |
| stat_w1c | input | 32 | Write-one-to-clear pulses for stat_o |
| miss_count | output | MISS_W | Missed frame counter |

## Verification
The bench sends frames with three kinds of destination: the station address, broadcast, and a unicast address that differs only in its last byte. It toggles the broadcast-reject and promiscuous bits so that each accept path is separated from the others. Frame lengths of 5, 6, 7, 8, 10 and 20 bytes are paired with capacities of 4, 8 and 64. This separates a frame in a single buffer, one that fits exactly, one that chains while the header is still being replayed, and one that chains through the payload. Descriptors left with ownership at the CPU show the difference between a drop at frame start and a truncation mid-frame. A narrowed miss counter is driven all the way through its wrap.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
   // control word fields
   localparam int CTRL_RXEN    = 4;
   localparam int CTRL_NOBC    = 8;
   localparam int CTRL_PROM    = 11;
   localparam int CTRL_LEN_LSB = 24;
   localparam int RING_W       = 8;

   // descriptor info word fields
   localparam int INFO_OWN   = 31;
   localparam int INFO_LAST  = 17;
   localparam int INFO_FIRST = 16;
   localparam int LEN_W      = 11;
   localparam int DESC_SHIFT = 3;   // 8 bytes per descriptor

   // status bits
   localparam int STAT_RX   = 1;
   localparam int STAT_MISS = 4;

   // destination address header
   localparam int HDR_N  = 6;
   localparam int HDR_IW = $clog2(HDR_N + 1);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_FILT,
      ST_RD_INFO,
      ST_RD_PTR,
      ST_CHK,
      ST_WRITE,
      ST_WB,
      ST_DISCARD
   } rrw_state_e;

   function automatic logic [31:0] info_word(input logic first, input logic last,
                                             input logic [LEN_W-1:0] len);
      logic [31:0] w;
      w = '0;
      w[INFO_FIRST]  = first;
      w[INFO_LAST]   = last;
      w[LEN_W-1:0]   = len;
      return w;
   endfunction
endpackage

// File: rtl/rrw_dest_filter.sv
module rrw_dest_filter
   import rrw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [HDR_IW-1:0] cap_idx,
   input  logic [7:0]        cap_byte,
   input  logic [HDR_IW-1:0] rd_idx,
   output logic [7:0]        rd_byte,
   input  logic [31:0]       sta_lo,
   input  logic [15:0]       sta_hi,
   input  logic              no_bcast,
   input  logic              promisc,
   output logic              accept
);
   logic [8*HDR_N-1:0] sta_flat;
   logic [7:0]         hb [HDR_N];
   logic [HDR_N-1:0]   is_sta;
   logic [HDR_N-1:0]   is_ff;

   assign sta_flat = {sta_hi, sta_lo};

   for (genvar i = 0; i < HDR_N; i++) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 hb[i] <= '0;
         else if (cap_en && cap_idx == HDR_IW'(i))   hb[i] <= cap_byte;
      end
      assign is_sta[i] = (hb[i] == sta_flat[8*i +: 8]);
      assign is_ff[i]  = &hb[i];
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < HDR_N; i++)
         if (rd_idx == HDR_IW'(i)) rd_byte = hb[i];
   end

   assign accept = promisc | (&is_sta) | ((&is_ff) & ~no_bcast);
endmodule

// File: rtl/rrw_events.sv
module rrw_events #(
   parameter int MISS_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic              miss_inc,
   input  logic              clr_rx,
   input  logic              clr_miss,
   output logic              rx_flag,
   output logic              miss_flag,
   output logic [MISS_W-1:0] miss_count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_flag    <= 1'b0;
         miss_flag  <= 1'b0;
         miss_count <= '0;
      end else begin
         if (rx_done)     rx_flag <= 1'b1;
         else if (clr_rx) rx_flag <= 1'b0;

         if (miss_inc) miss_count <= miss_count + 1'b1;

         if (miss_inc && (&miss_count)) miss_flag <= 1'b1;
         else if (clr_miss)             miss_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rrw_pkg::*;
#(
   parameter int AW     = 32,
   parameter int MISS_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_ctrl,
   input  logic [AW-1:0]     cfg_ring_base,
   input  logic [31:0]       cfg_addr_lo,
   input  logic [15:0]       cfg_addr_hi,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_wstrb,
   input  logic [31:0]       mem_rdata,
   output logic [31:0]       stat_o,
   input  logic [31:0]       stat_w1c,
   output logic [MISS_W-1:0] miss_count
);
   if (AW < 12 || AW > 32) begin : g_bad_aw
      $error("rx_ring_writer: AW must lie in 12..32");
   end
   if (MISS_W < 2) begin : g_bad_miss
      $error("rx_ring_writer: MISS_W must be at least 2");
   end

   localparam logic [HDR_IW-1:0] HDR_END = HDR_IW'(HDR_N);
   localparam logic [HDR_IW-1:0] HDR_TOP = HDR_IW'(HDR_N - 1);

   rrw_state_e        state;
   logic [HDR_IW-1:0] hcnt, rp;
   logic              hdr_last;
   logic [RING_W-1:0] idx, idx_nxt;
   logic [LEN_W-1:0]  cap, cnt;
   logic              own;
   logic [AW-1:0]     ptr;
   logic              first_q, last_q;

   logic [RING_W-1:0] ring_len;
   logic              rx_en, no_bcast, promisc;
   logic [AW-1:0]     desc_addr, buf_addr;
   logic              replaying, src_have, src_last, byte_fire;
   logic [7:0]        src_byte, hdr_byte;
   logic              accept, cap_en;
   logic [HDR_IW-1:0] cap_idx;
   logic              rx_done, miss_inc, rx_flag, miss_flag;
   logic              ctrl_unused;

   assign ring_len = cfg_ctrl[CTRL_LEN_LSB +: RING_W];
   assign rx_en    = cfg_ctrl[CTRL_RXEN];
   assign no_bcast = cfg_ctrl[CTRL_NOBC];
   assign promisc  = cfg_ctrl[CTRL_PROM];
   assign ctrl_unused = ^{cfg_ctrl[23:12], cfg_ctrl[10:9], cfg_ctrl[7:5], cfg_ctrl[3:0],
                          stat_w1c[31:5], stat_w1c[3:2], stat_w1c[0]};

   assign desc_addr = cfg_ring_base + (AW'(idx) << DESC_SHIFT);
   assign buf_addr  = ptr + AW'(cnt);
   assign idx_nxt   = (idx + 1'b1 == ring_len) ? '0 : idx + 1'b1;

   // byte source: header replay first, then live stream
   assign replaying = (rp < HDR_END);
   assign src_byte  = replaying ? hdr_byte : s_data;
   assign src_have  = replaying | s_valid;
   assign src_last  = replaying ? ((rp == HDR_TOP) & hdr_last) : s_last;
   assign byte_fire = (state == ST_WRITE) & src_have;

   assign s_ready = (state == ST_IDLE) | (state == ST_HDR) | (state == ST_DISCARD) |
                    ((state == ST_WRITE) & ~replaying);

   assign cap_en  = ((state == ST_IDLE) & s_valid & rx_en) | ((state == ST_HDR) & s_valid);
   assign cap_idx = (state == ST_IDLE) ? '0 : hcnt;

   rrw_dest_filter u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_byte (s_data),
      .rd_idx   (rp),
      .rd_byte  (hdr_byte),
      .sta_lo   (cfg_addr_lo),
      .sta_hi   (cfg_addr_hi),
      .no_bcast (no_bcast),
      .promisc  (promisc),
      .accept   (accept)
   );

   // memory port
   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = desc_addr;
      mem_wdata = {4{src_byte}};
      mem_wstrb = 4'b0001 << buf_addr[1:0];
      unique case (state)
         ST_RD_INFO: mem_rd = 1'b1;
         ST_RD_PTR: begin
            mem_rd   = 1'b1;
            mem_addr = desc_addr + AW'(4);
         end
         ST_WRITE: begin
            mem_wr   = src_have;
            mem_addr = buf_addr;
         end
         ST_WB: begin
            mem_wr    = 1'b1;
            mem_wdata = info_word(first_q, last_q, cnt);
            mem_wstrb = 4'hF;
         end
         default: ;
      endcase
   end

   assign rx_done  = (state == ST_WB) & last_q;
   assign miss_inc = (state == ST_CHK) & ~own;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hcnt     <= '0;
         rp       <= '0;
         hdr_last <= 1'b0;
         idx      <= '0;
         cap      <= '0;
         cnt      <= '0;
         own      <= 1'b0;
         ptr      <= '0;
         first_q  <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (s_valid) begin
               if (!rx_en) begin
                  if (!s_last) state <= ST_DISCARD;
               end else if (!s_last) begin
                  hcnt  <= HDR_IW'(1);
                  state <= ST_HDR;
               end
            end
            ST_HDR: if (s_valid) begin
               if (hcnt == HDR_TOP) begin
                  hdr_last <= s_last;
                  state    <= ST_FILT;
               end else if (s_last) begin
                  state <= ST_IDLE;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            ST_FILT: begin
               if (accept) begin
                  first_q <= 1'b1;
                  rp      <= '0;
                  state   <= ST_RD_INFO;
               end else begin
                  state <= hdr_last ? ST_IDLE : ST_DISCARD;
               end
            end
            ST_RD_INFO: state <= ST_RD_PTR;
            ST_RD_PTR: begin
               cap   <= mem_rdata[LEN_W-1:0];
               own   <= mem_rdata[INFO_OWN];
               state <= ST_CHK;
            end
            ST_CHK: begin
               ptr <= mem_rdata[AW-1:0];
               cnt <= '0;
               if (own)                        state <= ST_WRITE;
               else if (replaying && hdr_last) state <= ST_IDLE;
               else                            state <= ST_DISCARD;
            end
            ST_WRITE: if (byte_fire) begin
               cnt <= cnt + 1'b1;
               if (replaying) rp <= rp + 1'b1;
               if (src_last) begin
                  last_q <= 1'b1;
                  state  <= ST_WB;
               end else if (cnt + 1'b1 == cap) begin
                  last_q <= 1'b0;
                  state  <= ST_WB;
               end
            end
            ST_WB: begin
               idx     <= idx_nxt;
               first_q <= 1'b0;
               state   <= last_q ? ST_IDLE : ST_RD_INFO;
            end
            ST_DISCARD: if (s_valid && s_last) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   rrw_events #(.MISS_W(MISS_W)) u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_done    (rx_done),
      .miss_inc   (miss_inc),
      .clr_rx     (stat_w1c[STAT_RX]),
      .clr_miss   (stat_w1c[STAT_MISS]),
      .rx_flag    (rx_flag),
      .miss_flag  (miss_flag),
      .miss_count (miss_count)
   );

   always_comb begin
      stat_o            = '0;
      stat_o[STAT_RX]   = rx_flag;
      stat_o[STAT_MISS] = miss_flag;
   end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
   parameter int MISS_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic              rd,
   input logic              wr,
   input logic [3:0]        strb,
   input logic              info_own,
   input logic              info_last,
   input logic              rx_flag,
   input logic              miss_flag,
   input logic [MISS_W-1:0] miss_count
);
   // R4: stream is held off while descriptor words are fetched
   a_r4_stall_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> !s_ready);

   // R4: reads and writes never share a cycle
   a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && wr));

   // R4: buffer writes use exactly one byte lane
   a_r4_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && strb != 4'hF) |-> ($countones(strb) == 1));

   // R5: every write-back returns ownership to the CPU
   a_r5_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && strb == 4'hF) |-> !info_own);

   // R10: receive status rises only after a final write-back
   a_r10_rx_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> $past(wr && strb == 4'hF && info_last));

   // R10: miss status rises together with the counter wrapping to zero
   a_r10_miss_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miss_flag) |-> (miss_count == '0));

   // R8: the missed counter only steps by one
   a_r8_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.MISS_W(MISS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s_ready    (s_ready),
   .rd         (mem_rd),
   .wr         (mem_wr),
   .strb       (mem_wstrb),
   .info_own   (mem_wdata[31]),
   .info_last  (mem_wdata[17]),
   .rx_flag    (stat_o[1]),
   .miss_flag  (stat_o[4]),
   .miss_count (miss_count)
);

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
   localparam int MW = 4;
   localparam logic [47:0] STA   = 48'h5544_3322_1102;
   localparam logic [47:0] OTHER = 48'h5644_3322_1102;
   localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [31:0]   cfg_ctrl;
   logic [31:0]   cfg_ring_base, cfg_addr_lo;
   logic [15:0]   cfg_addr_hi;
   logic          s_valid, s_last, s_ready;
   logic [7:0]    s_data;
   logic          mem_rd, mem_wr;
   logic [31:0]   mem_addr, mem_wdata, mem_rdata;
   logic [3:0]    mem_wstrb;
   logic [31:0]   stat_o, stat_w1c;
   logic [MW-1:0] miss_count;

   rx_ring_writer #(.AW(32), .MISS_W(MW)) u_rx_ring_writer (
      .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_ring_base(cfg_ring_base),
      .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
      .stat_o(stat_o), .stat_w1c(stat_w1c), .miss_count(miss_count));

   logic [31:0] mem [512];
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];
      if (mem_wr)
         for (int b = 0; b < 4; b++)
            if (mem_wstrb[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
   end

   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic int bufa(int i);
      return 256 + 128*i + i;
   endfunction
   function automatic logic [7:0] fb(logic [47:0] da, int seed, int k);
      return (k < 6) ? da[8*k +: 8] : 8'(seed + k);
   endfunction
   function automatic logic [7:0] rdb(int a);
      return mem[a >> 2][(a & 3)*8 +: 8];
   endfunction
   function automatic logic [31:0] mkctrl(bit en, bit nobc, bit prom);
      return (32'd4 << 24) | (32'(en) << 4) | (32'(nobc) << 8) | (32'(prom) << 11);
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic arm(int i, int cap);
      mem[2*i]   = 32'h8000_0000 | 32'(cap);
      mem[2*i+1] = 32'(bufa(i));
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(logic [47:0] da, int len, int seed);
      bit rdy;
      for (int k = 0; k < len; k++) begin
         s_valid = 1'b1;
         s_data  = fb(da, seed, k);
         s_last  = (k == len - 1);
         do begin
            rdy = s_ready;
            @(negedge clk);
         end while (!rdy);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
      wait_n(30);
   endtask

   task automatic chk_bytes(int i, logic [47:0] da, int seed, int k0, int n, string tag);
      bit ok = 1;
      logic [7:0] a = '0, e = '0;
      for (int j = 0; j < n; j++)
         if (ok && rdb(bufa(i) + j) !== fb(da, seed, k0 + j)) begin
            ok = 0; a = rdb(bufa(i) + j); e = fb(da, seed, k0 + j);
         end
      check(ok, tag, 32'(a), 32'(e));
   endtask

   task automatic w1c(logic [31:0] m);
      stat_w1c = m;
      @(negedge clk);
      stat_w1c = '0;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired before the sequence ended");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = '0;
      rst_n = 1'b0; s_valid = 0; s_last = 0; s_data = 0; stat_w1c = 0;
      cfg_ctrl = mkctrl(1, 0, 0); cfg_ring_base = 32'h0;
      cfg_addr_lo = STA[31:0]; cfg_addr_hi = STA[47:32];
      wait_n(3);
      // R1 reset state
      check(s_ready === 1'b1, "R1 s_ready", 32'(s_ready), 1);
      check(stat_o === 32'h0, "R1 stat_o", stat_o, 0);
      check(miss_count === '0, "R1 miss_count", 32'(miss_count), 0);
      check({mem_rd, mem_wr} === 2'b00, "R1 memory idle", 32'({mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      wait_n(2);

      // R2 R4 R5: station frame into one buffer
      for (int i = 0; i < 4; i++) arm(i, 64);
      send(STA, 10, 16);
      check(mem[0] === 32'h0003_000A, "R5 single info", mem[0], 32'h0003_000A);
      chk_bytes(0, STA, 16, 0, 10, "R4 bytes desc0");
      check(stat_o[1] === 1'b1, "R10 rx flag set", stat_o, 32'h2);
      w1c(32'h2);
      check(stat_o[1] === 1'b0, "R10 rx flag cleared", stat_o, 0);

      // R6: 20 bytes over three 8-byte buffers
      for (int i = 1; i < 4; i++) arm(i, 8);
      send(STA, 20, 64);
      check(mem[2] === 32'h0001_0008, "R6 chain first", mem[2], 32'h0001_0008);
      check(mem[4] === 32'h0000_0008, "R6 chain middle", mem[4], 32'h0000_0008);
      check(mem[6] === 32'h0002_0004, "R6 chain last", mem[6], 32'h0002_0004);
      chk_bytes(1, STA, 64, 0, 8, "R6 bytes desc1");
      chk_bytes(2, STA, 64, 8, 8, "R6 bytes desc2");
      chk_bytes(3, STA, 64, 16, 4, "R6 bytes desc3");

      // R7 wrap to index 0, R6 exact capacity
      arm(0, 8);
      send(STA, 8, 128);
      check(mem[0] === 32'h0003_0008, "R7 wrap / R6 exact fit", mem[0], 32'h0003_0008);
      chk_bytes(0, STA, 128, 0, 8, "R6 bytes exact");

      // R3 broadcast accepted
      arm(1, 64);
      send(BC, 12, 3);
      check(mem[2] === 32'h0003_000C, "R3 broadcast", mem[2], 32'h0003_000C);
      chk_bytes(1, BC, 3, 0, 12, "R3 broadcast bytes");
      w1c(32'h2);

      // R3 broadcast rejected, R2 foreign unicast rejected
      arm(2, 64);
      cfg_ctrl = mkctrl(1, 1, 0);
      send(BC, 12, 5);
      check(mem[4] === 32'h8000_0040, "R3 broadcast rejected", mem[4], 32'h8000_0040);
      send(OTHER, 12, 5);
      check(mem[4] === 32'h8000_0040, "R2 foreign rejected", mem[4], 32'h8000_0040);
      check(stat_o[1] === 1'b0, "R2 no rx flag on drop", stat_o, 0);

      // R3 promiscuous
      cfg_ctrl = mkctrl(1, 1, 1);
      send(OTHER, 15, 7);
      check(mem[4] === 32'h0003_000F, "R3 promiscuous", mem[4], 32'h0003_000F);
      chk_bytes(2, OTHER, 7, 0, 15, "R3 promiscuous bytes");
      cfg_ctrl = mkctrl(1, 0, 0);

      // R11 short frame and receive disabled
      arm(3, 64);
      send(STA, 5, 9);
      check(mem[6] === 32'h8000_0040, "R11 short dropped", mem[6], 32'h8000_0040);
      cfg_ctrl = mkctrl(0, 0, 0);
      send(STA, 10, 9);
      check(mem[6] === 32'h8000_0040, "R11 disabled dropped", mem[6], 32'h8000_0040);
      check(miss_count === 4'd0, "R11 no miss count", 32'(miss_count), 0);
      cfg_ctrl = mkctrl(1, 0, 0);

      // R2 six-byte frame (header only)
      send(STA, 6, 9);
      check(mem[6] === 32'h0003_0006, "R2 six-byte frame", mem[6], 32'h0003_0006);

      // R4 capacity from info, chaining during header
      arm(0, 4); arm(1, 4);
      send(STA, 7, 33);
      check(mem[0] === 32'h0001_0004, "R4 cap4 first", mem[0], 32'h0001_0004);
      check(mem[2] === 32'h0002_0003, "R4 cap4 last", mem[2], 32'h0002_0003);
      chk_bytes(0, STA, 33, 0, 4, "R4 bytes cap4 a");
      chk_bytes(1, STA, 33, 4, 3, "R4 bytes cap4 b");

      // R8 CPU-owned at frame start (desc2)
      send(STA, 10, 1);
      check(miss_count === 4'd1, "R8 miss count", 32'(miss_count), 1);
      check(mem[4] === 32'h0003_000F, "R8 desc untouched", mem[4], 32'h0003_000F);
      check(stat_o[4] === 1'b0, "R10 no miss flag yet", stat_o, 0);

      // R9 truncation mid-frame: desc2 cap4, desc3 CPU-owned
      w1c(32'h2);
      arm(2, 4);
      send(STA, 10, 2);
      check(mem[4] === 32'h0001_0004, "R9 first without last", mem[4], 32'h0001_0004);
      check(miss_count === 4'd2, "R9 miss count", 32'(miss_count), 2);
      check(stat_o[1] === 1'b0, "R9 no rx flag", stat_o, 0);
      arm(3, 64);
      send(STA, 9, 4);
      check(mem[6] === 32'h0003_0009, "R9 index held", mem[6], 32'h0003_0009);

      // R10 counter wrap (desc0 CPU-owned)
      for (int f = 0; f < 13; f++) send(STA, 8, f);
      check(miss_count === 4'd15 && stat_o[4] === 1'b0, "R10 before wrap",
            {stat_o[4], 27'd0, miss_count}, 32'h0000_000F);
      send(STA, 8, 99);
      check(miss_count === 4'd0, "R10 wrap count", 32'(miss_count), 0);
      check(stat_o[4] === 1'b1, "R10 miss flag", stat_o, 32'h10);
      w1c(32'h10);
      check(stat_o[4] === 1'b0, "R10 miss flag cleared", stat_o, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule